// File: doc/BRIEF.md
# SDRAM Bank Precharge State Tracker

This block follows a stream of decoded SDRAM commands and keeps a small state machine for each bank. A bank is idle, open (a row is active), accessing with a pending automatic close, or closing (precharge in progress). The block applies the closing rules to every command: explicit single-bank and all-bank precharge, automatic precharge requested on a read or write, the lock-out that keeps a row open for a minimum active time, write recovery, and the precharge time before a bank can be reopened.

The timing values arrive as cycle counts on input ports, so one instance serves any speed grade. One command is presented per clock. The block reports each bank's state and raises a one-cycle flag, with the bank number, for a command the addressed bank cannot accept. A separate per-bank flag reports a precharge that came before the row-active minimum. Such a precharge is not carried out. A memory controller or a protocol monitor uses these outputs to check its own scheduling.

Top module: `sdram_bank_tracker`

## Requirements
- R1: While reset is high at a clock edge, every bank becomes idle, and the illegal and timing-violation flags read 0 after that edge.
- R2: Command codes on `cmd_i` are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4, and the codes 5 to 7 act as NOP. Bank b's state sits in `bank_state_o[2b+1:2b]` as idle=0, open=1, auto-close=2, closing=3. An ACTIVATE to an idle bank makes it open after that edge.
- R3: A PRECHARGE with `a10_i` low closes only the bank on `ba_i`, once at least `t_ras_i` cycles have passed since its ACTIVATE. The bank reads closing for exactly `t_rp_i` cycles and then idle. An ACTIVATE issued `t_rp_i` cycles after the precharge is accepted. The other banks are not touched. All four timing inputs must be at least 1.
- R4: A PRECHARGE with `a10_i` high closes every open bank, whatever `ba_i` holds. Idle banks stay idle.
- R5: A PRECHARGE to an idle bank or to a closing bank does nothing. The state and the remaining precharge time stay unchanged, and no flag is raised.
- R6: A PRECHARGE that reaches an open bank fewer than `t_ras_i` cycles after its ACTIVATE is not executed. The bank stays open, and its bit in `tras_viol_o` is 1 for the cycle after the command.
- R7: A READ or WRITE with `a10_i` low leaves an open bank open. An automatic-close request applies to its own command only.
- R8: A READ with `a10_i` high at edge E puts the bank in auto-close. It starts closing at edge max(E + `burst_clks_i`, A + `t_ras_i`), where A is the ACTIVATE edge, and is closing for `t_rp_i` cycles after that.
- R9: A WRITE with `a10_i` high at edge E starts closing at edge max(E + 1 + `burst_clks_i` + `t_wr_i`, A + `t_ras_i`). The closing phase then lasts `t_rp_i` cycles.
- R10: A READ or WRITE to a bank that is idle, auto-closing or closing, or an ACTIVATE to a bank that is not idle, is refused. The bank's state is unchanged, `illegal_o` is 1 for the cycle after the command, and `illegal_bank_o` holds the bank number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cmd_i | input | 3 | Command code (see R2) |
| ba_i | input | 2 | Bank address |
| a10_i | input | 1 | All-bank select for PRECHARGE, automatic-close request for READ and WRITE |
| t_ras_i | input | 5 | Minimum row-active time in cycles |
| t_rp_i | input | 5 | Precharge time in cycles |
| t_wr_i | input | 5 | Write recovery in cycles |
| burst_clks_i | input | 5 | Burst duration in cycles |
| bank_state_o | output | 8 | Two-bit state per bank |
| illegal_o | output | 1 | Refused-command pulse |
| illegal_bank_o | output | 2 | Bank of the refused command |
| tras_viol_o | output | 4 | Per-bank early-precharge pulse |

## Verification
The bench sends an early precharge. A design that ignored the row-active lock-out would close the bank there and raise no violation bit. It sends a second precharge into a bank that is already closing and then reopens the bank at exactly the end of the precharge time. A design that restarted the timer would refuse that ACTIVATE, and a design that kept the bank closing one cycle too long would do the same. Automatic-close reads are issued both well after the ACTIVATE and right after it, so that a design taking only the burst end, or only the row-active time, starts closing at the wrong cycle. It also sends an all-bank precharge while one bank is still too young, and that bank alone must stay open.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [1:0] {
        BK_IDLE    = 2'd0,
        BK_OPEN    = 2'd1,
        BK_AUTO    = 2'd2,
        BK_CLOSING = 2'd3
    } bank_st_e;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } op_e;

endpackage

// File: rtl/bank_cmd_decode.sv
module bank_cmd_decode
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic [2:0]           cmd_i,
    input  logic [BA_W-1:0]      ba_i,
    input  logic                 a10_i,
    output op_e                  op_o,
    output logic [NUM_BANKS-1:0] hit_o,
    output logic                 ap_o
);

    always_comb begin
        case (cmd_i)
            3'd1:    op_o = OP_ACT;
            3'd2:    op_o = OP_RD;
            3'd3:    op_o = OP_WR;
            3'd4:    op_o = OP_PRE;
            default: op_o = OP_NOP;
        endcase

        hit_o = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (op_o != OP_NOP) begin
                // all-bank close ignores the bank address
                if (op_o == OP_PRE && a10_i)
                    hit_o[b] = 1'b1;
                else if (ba_i == BA_W'(b))
                    hit_o[b] = 1'b1;
            end
        end

        ap_o = a10_i && (op_o == OP_RD || op_o == OP_WR);
    end

endmodule

// File: rtl/bank_fsm.sv
module bank_fsm
    import bank_trk_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int ACC_W = CNT_W + 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  op_e              op_i,
    input  logic             hit_i,
    input  logic             ap_i,
    input  logic [CNT_W-1:0] t_ras_i,
    input  logic [CNT_W-1:0] t_rp_i,
    input  logic [CNT_W-1:0] t_wr_i,
    input  logic [CNT_W-1:0] burst_i,
    output bank_st_e         state_o,
    output logic             illegal_o,
    output logic             viol_o
);

    typedef struct packed {
        bank_st_e         state;
        logic [CNT_W-1:0] ras;   // cycles left until row-active minimum is met
        logic [ACC_W-1:0] acc;   // cycles left in the access period
        logic [CNT_W-1:0] rp;    // cycles left in the precharge period
    } bank_reg_t;

    bank_reg_t        bank_q, bank_d;
    logic             ill_d, viol_d;
    logic             is_act, is_rw, is_pre;
    logic [ACC_W-1:0] rd_len, wr_len, acc_load;

    assign is_act = (op_i == OP_ACT);
    assign is_rw  = (op_i == OP_RD) || (op_i == OP_WR);
    assign is_pre = (op_i == OP_PRE);

    // read: closes once the burst is out; write: one latency cycle, burst, then recovery
    assign rd_len   = ACC_W'(burst_i);
    assign wr_len   = ACC_W'(burst_i) + ACC_W'(t_wr_i) + ACC_W'(1);
    assign acc_load = ((op_i == OP_WR) ? wr_len : rd_len) - ACC_W'(1);

    always_comb begin
        bank_d = bank_q;
        ill_d  = 1'b0;
        viol_d = 1'b0;

        if (bank_q.ras != '0)
            bank_d.ras = bank_q.ras - CNT_W'(1);

        case (bank_q.state)
            BK_IDLE: begin
                if (hit_i && is_act) begin
                    bank_d.state = BK_OPEN;
                    bank_d.ras   = t_ras_i - CNT_W'(1);
                end else if (hit_i && is_rw) begin
                    ill_d = 1'b1;
                end
            end
            BK_OPEN: begin
                if (hit_i && is_act) begin
                    ill_d = 1'b1;
                end else if (hit_i && is_rw && ap_i) begin
                    bank_d.state = BK_AUTO;
                    bank_d.acc   = acc_load;
                end else if (hit_i && is_pre) begin
                    if (bank_q.ras == '0) begin
                        bank_d.state = BK_CLOSING;
                        bank_d.rp    = t_rp_i - CNT_W'(1);
                    end else begin
                        viol_d = 1'b1;
                    end
                end
            end
            BK_AUTO: begin
                if (hit_i && (is_act || is_rw))
                    ill_d = 1'b1;
                // internal close waits for both the access end and the lock-out
                if (bank_q.acc == '0 && bank_q.ras == '0) begin
                    bank_d.state = BK_CLOSING;
                    bank_d.rp    = t_rp_i - CNT_W'(1);
                end else if (bank_q.acc != '0) begin
                    bank_d.acc = bank_q.acc - ACC_W'(1);
                end
            end
            default: begin
                if (bank_q.rp == '0) begin
                    bank_d.state = BK_IDLE;
                    if (hit_i && is_act) begin
                        bank_d.state = BK_OPEN;
                        bank_d.ras   = t_ras_i - CNT_W'(1);
                    end else if (hit_i && is_rw) begin
                        ill_d = 1'b1;
                    end
                end else begin
                    bank_d.rp = bank_q.rp - CNT_W'(1);
                    if (hit_i && (is_act || is_rw))
                        ill_d = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) bank_q <= '0;
        else       bank_q <= bank_d;
    end

    assign state_o   = bank_q.state;
    assign illegal_o = ill_d;
    assign viol_o    = viol_d;

    // ---------------- assertion-side age counters ----------------
    logic [CNT_W:0]   act_age_q;
    logic [CNT_W-1:0] rp_age_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            act_age_q <= '0;
            rp_age_q  <= '0;
        end else begin
            if (bank_q.state != BK_OPEN && bank_d.state == BK_OPEN)
                act_age_q <= (CNT_W+1)'(1);
            else if (act_age_q != '1)
                act_age_q <= act_age_q + (CNT_W+1)'(1);
            if (bank_q.state == BK_CLOSING)
                rp_age_q <= rp_age_q + CNT_W'(1);
            else
                rp_age_q <= '0;
        end
    end

    assert_tras_lockout_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        ((bank_q.state == BK_OPEN || bank_q.state == BK_AUTO) && bank_d.state == BK_CLOSING)
        |-> (act_age_q >= {1'b0, t_ras_i}));

    assert_rp_window_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bank_q.state == BK_CLOSING) |-> (rp_age_q < t_rp_i));

    assert_rp_full_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (bank_q.state == BK_CLOSING && bank_d.state != BK_CLOSING)
        |-> (rp_age_q == t_rp_i - CNT_W'(1)));

    assert_pre_idle_ignored_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (bank_q.state == BK_IDLE && hit_i && is_pre) |=> (bank_q.state == BK_IDLE));

    assert_ap_nonpersist_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (bank_q.state == BK_OPEN && hit_i && is_rw && !ap_i) |=> (bank_q.state == BK_OPEN));

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 5,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [2:0]             cmd_i,
    input  logic [BA_W-1:0]        ba_i,
    input  logic                   a10_i,
    input  logic [CNT_W-1:0]       t_ras_i,
    input  logic [CNT_W-1:0]       t_rp_i,
    input  logic [CNT_W-1:0]       t_wr_i,
    input  logic [CNT_W-1:0]       burst_clks_i,
    output logic [2*NUM_BANKS-1:0] bank_state_o,
    output logic                   illegal_o,
    output logic [BA_W-1:0]        illegal_bank_o,
    output logic [NUM_BANKS-1:0]   tras_viol_o
);

    typedef struct packed {
        logic                 ill;
        logic [BA_W-1:0]      ill_bank;
        logic [NUM_BANKS-1:0] viol;
    } flag_t;

    op_e                  op;
    logic [NUM_BANKS-1:0] hit, ill_vec, viol_vec;
    logic                 ap;
    bank_st_e             st [NUM_BANKS];
    flag_t                flag_q, flag_d;

    bank_cmd_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_decode (
        .cmd_i (cmd_i),
        .ba_i  (ba_i),
        .a10_i (a10_i),
        .op_o  (op),
        .hit_o (hit),
        .ap_o  (ap)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_fsm #(.CNT_W(CNT_W)) u_bank (
            .clk_i     (clk_i),
            .rst_i     (rst_i),
            .op_i      (op),
            .hit_i     (hit[g]),
            .ap_i      (ap),
            .t_ras_i   (t_ras_i),
            .t_rp_i    (t_rp_i),
            .t_wr_i    (t_wr_i),
            .burst_i   (burst_clks_i),
            .state_o   (st[g]),
            .illegal_o (ill_vec[g]),
            .viol_o    (viol_vec[g])
        );
        assign bank_state_o[2*g +: 2] = st[g];
    end

    always_comb begin
        flag_d.ill      = |ill_vec;
        flag_d.ill_bank = '0;
        flag_d.viol     = viol_vec;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (ill_vec[b]) flag_d.ill_bank = BA_W'(b);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) flag_q <= '0;
        else       flag_q <= flag_d;
    end

    assign illegal_o      = flag_q.ill;
    assign illegal_bank_o = flag_q.ill_bank;
    assign tras_viol_o    = flag_q.viol;

    assert_cfg_nonzero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (t_ras_i != '0) && (t_rp_i != '0) && (t_wr_i != '0) && (burst_clks_i != '0));

    assert_rw_idle_flag_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        ((cmd_i == 3'd2 || cmd_i == 3'd3) && bank_state_o[int'(ba_i)*2 +: 2] == 2'd0)
        |=> (illegal_o && illegal_bank_o == $past(ba_i)));

endmodule

// File: tb/tb_sdram_bank_tracker.sv
module tb_sdram_bank_tracker;

    localparam int ST_IDLE = 0;
    localparam int ST_OPEN = 1;
    localparam int ST_AUTO = 2;
    localparam int ST_CLS  = 3;
    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3, C_PRE = 3'd4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd = 3'd0;
    logic [1:0] ba = 2'd0;
    logic       a10 = 1'b0;
    logic [4:0] t_ras = 5'd6, t_rp = 5'd3, t_wr = 5'd2, burst = 5'd2;
    logic [7:0] bank_state;
    logic       illegal;
    logic [1:0] illegal_bank;
    logic [3:0] tras_viol;

    sdram_bank_tracker dut (
        .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .ba_i(ba), .a10_i(a10),
        .t_ras_i(t_ras), .t_rp_i(t_rp), .t_wr_i(t_wr), .burst_clks_i(burst),
        .bank_state_o(bank_state), .illegal_o(illegal),
        .illegal_bank_o(illegal_bank), .tras_viol_o(tras_viol)
    );

    always #10ns clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    kind;   // 0 bank state, 1 illegal (-1 none, else bank), 2 violation mask
        int    bank;
        int    val;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   errors = 0;

    task automatic push(input exp_t it);
        int i = 0;
        while (i < sb.size() && sb[i].at <= it.at) i++;
        sb.insert(i, it);
    endtask

    task automatic exp_st(input int at, input int b, input int s, input string tag);
        exp_t it;
        it.at = at; it.kind = 0; it.bank = b; it.val = s; it.tag = tag;
        push(it);
    endtask

    task automatic exp_ill(input int at, input int b, input string tag);
        exp_t it;
        it.at = at; it.kind = 1; it.bank = 0; it.val = b; it.tag = tag;
        push(it);
    endtask

    task automatic exp_viol(input int at, input int mask, input string tag);
        exp_t it;
        it.at = at; it.kind = 2; it.bank = 0; it.val = mask; it.tag = tag;
        push(it);
    endtask

    // drive a command so that it is captured at clock edge number e
    task automatic issue(input int e, input logic [2:0] c, input int b, input logic a);
        while (cyc != e - 1) @(negedge clk);
        cmd = c; ba = 2'(b); a10 = a;
        @(negedge clk);
        cmd = C_NOP; ba = 2'd0; a10 = 1'b0;
    endtask

    // monitor: compares scheduled expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t it;
            int   act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = int'(bank_state[it.bank*2 +: 2]);
                1:       act = illegal ? int'(illegal_bank) : -1;
                default: act = int'(tras_viol);
            endcase
            checks++;
            if (it.at != cyc) begin
                errors++;
                $display("FAIL %s: check scheduled at cycle %0d missed (now %0d), actual=%0d expected=%0d",
                         it.tag, it.at, cyc, act, it.val);
            end else if (act != it.val) begin
                errors++;
                $display("FAIL %s: cycle %0d kind %0d bank %0d actual=%0d expected=%0d",
                         it.tag, cyc, it.kind, it.bank, act, it.val);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        int t, u;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        for (int b = 0; b < 4; b++) exp_st(cyc + 1, b, ST_IDLE, "R1");
        exp_ill(cyc + 1, -1, "R1");
        exp_viol(cyc + 1, 0, "R1");
        t = cyc + 3;

        // R2: open bank 0
        exp_st(t, 0, ST_OPEN, "R2");
        exp_ill(t, -1, "R2");
        issue(t, C_ACT, 0, 1'b0);
        // R6: early precharge refused
        exp_viol(t + 2, 1, "R6");
        exp_st(t + 3, 0, ST_OPEN, "R6");
        issue(t + 2, C_PRE, 0, 1'b0);
        // R5: precharge to idle bank 1 ignored
        exp_viol(t + 4, 0, "R5");
        exp_st(t + 4, 1, ST_IDLE, "R5");
        issue(t + 4, C_PRE, 1, 1'b0);
        // R3: legal single-bank close
        exp_st(t + 6, 0, ST_CLS, "R3");
        exp_st(t + 6, 1, ST_IDLE, "R3");
        exp_st(t + 8, 0, ST_CLS, "R3");
        issue(t + 6, C_PRE, 0, 1'b0);
        // R5: second precharge while closing ignored, timer not restarted
        exp_viol(t + 7, 0, "R5");
        exp_st(t + 7, 0, ST_CLS, "R5");
        issue(t + 7, C_PRE, 0, 1'b0);
        // R3: reopen exactly t_rp after the close
        exp_st(t + 9, 0, ST_OPEN, "R3");
        exp_ill(t + 9, -1, "R3");
        issue(t + 9, C_ACT, 0, 1'b0);

        issue(t + 10, C_ACT, 1, 1'b0);
        issue(t + 11, C_ACT, 2, 1'b0);
        // R10: ACTIVATE to open bank, READ to idle bank
        exp_ill(t + 12, 0, "R10");
        exp_st(t + 13, 0, ST_OPEN, "R10");
        issue(t + 12, C_ACT, 0, 1'b0);
        exp_ill(t + 13, 3, "R10");
        exp_st(t + 14, 3, ST_IDLE, "R10");
        issue(t + 13, C_RD, 3, 1'b0);
        // R4: all-bank close, bank address ignored
        exp_st(t + 17, 0, ST_CLS, "R4");
        exp_st(t + 17, 1, ST_CLS, "R4");
        exp_st(t + 17, 2, ST_CLS, "R4");
        exp_st(t + 17, 3, ST_IDLE, "R4");
        exp_viol(t + 17, 0, "R4");
        issue(t + 17, C_PRE, 3, 1'b1);
        // R10: READ to closing bank
        exp_ill(t + 18, 1, "R10");
        issue(t + 18, C_RD, 1, 1'b0);
        for (int b = 0; b < 4; b++) exp_st(t + 20, b, ST_IDLE, "R4");

        // R4 + R6: all-bank close with one bank too young
        issue(t + 21, C_ACT, 0, 1'b0);
        issue(t + 25, C_ACT, 1, 1'b0);
        exp_viol(t + 28, 2, "R6");
        exp_st(t + 28, 0, ST_CLS, "R4");
        exp_st(t + 29, 1, ST_OPEN, "R6");
        issue(t + 28, C_PRE, 0, 1'b1);

        u = t + 32;
        // R7: plain read and write keep the bank open
        exp_ill(u, -1, "R7");
        exp_st(u + 2, 1, ST_OPEN, "R7");
        issue(u, C_RD, 1, 1'b0);
        exp_st(u + 3, 1, ST_OPEN, "R7");
        issue(u + 2, C_WR, 1, 1'b0);
        // R8: read with auto close, burst end dominates
        exp_st(u + 4, 1, ST_AUTO, "R8");
        exp_st(u + 5, 1, ST_AUTO, "R8");
        exp_st(u + 6, 1, ST_CLS, "R8");
        exp_st(u + 8, 1, ST_CLS, "R8");
        exp_st(u + 9, 1, ST_IDLE, "R8");
        issue(u + 4, C_RD, 1, 1'b1);
        // R8: read with auto close, row-active lock-out dominates
        issue(u + 10, C_ACT, 2, 1'b0);
        exp_st(u + 11, 2, ST_AUTO, "R8");
        exp_st(u + 15, 2, ST_AUTO, "R8");
        exp_st(u + 16, 2, ST_CLS, "R8");
        exp_st(u + 18, 2, ST_CLS, "R8");
        exp_st(u + 19, 2, ST_IDLE, "R8");
        issue(u + 11, C_RD, 2, 1'b1);
        // R10: READ to auto-closing bank
        exp_ill(u + 12, 2, "R10");
        exp_st(u + 13, 2, ST_AUTO, "R10");
        issue(u + 12, C_RD, 2, 1'b0);

        // R9: write with auto close after recovery
        issue(u + 20, C_ACT, 3, 1'b0);
        exp_st(u + 27, 3, ST_AUTO, "R9");
        exp_st(u + 31, 3, ST_AUTO, "R9");
        exp_st(u + 32, 3, ST_CLS, "R9");
        exp_st(u + 34, 3, ST_CLS, "R9");
        exp_st(u + 35, 3, ST_IDLE, "R9");
        issue(u + 27, C_WR, 3, 1'b1);
        // R9: write issued right after activate
        issue(u + 36, C_ACT, 0, 1'b0);
        exp_st(u + 41, 0, ST_AUTO, "R9");
        exp_st(u + 42, 0, ST_CLS, "R9");
        exp_st(u + 45, 0, ST_IDLE, "R9");
        issue(u + 37, C_WR, 0, 1'b1);

        while (cyc < u + 48) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule